// File: doc/BRIEF.md
# Bit interleave shuffle unit

This execution unit takes two W-bit source words and merges one half of each into a single W-bit result. The bits are taken one at a time, first from source A and then from source B. A half select input chooses which halves are merged. The low variant uses bits [W/2-1:0] of both sources. The high variant uses bits [W-1:W/2] of both sources.

Its main use is squaring in binary polynomial fields. Squaring a polynomial over GF(2) places a zero between each pair of coefficients. Driving source B with zero therefore gives the unreduced square of the chosen half of source A. Issuing the low variant and then the high variant on the same sources gives the full 2W-bit interleave as two words.

The unit completes in a single cycle. By default the result is captured in an output register, so it appears one clock after the operands are presented. A parameter can remove this register and leave a purely combinational path.

Top module: `bitmix_shuffle_unit`

## Requirements
- R1: With hi_sel = 0, result bit 2i equals src_a bit i and result bit 2i+1 equals src_b bit i, for i in 0..W/2-1.
- R2: With hi_sel = 1, result bit 2i equals src_a bit W/2+i and result bit 2i+1 equals src_b bit W/2+i, for i in 0..W/2-1.
- R3: With hi_sel = 0, bits [W-1:W/2] of both sources have no effect on the result.
- R4: With hi_sel = 1, bits [W/2-1:0] of both sources have no effect on the result.
- R5: With src_b = 0, the result equals the carry-less product of the selected half of src_a with itself, and every odd result bit is 0.
- R6: For fixed sources, the result with hi_sel = 1 placed above the result with hi_sel = 0 forms the full 2W-bit interleave: bit 2j is src_a bit j and bit 2j+1 is src_b bit j.
- R7: With the output register present (REG_OUT = 1), the result reflects the operands sampled at the previous rising clock edge. It does not change between clock edges.
- R8: While rst_n is low, the registered result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | W | Source A; supplies the even result bits |
| src_b | input | W | Source B; supplies the odd result bits |
| hi_sel | input | 1 | Half select: 0 merges the lower halves, 1 merges the upper halves |
| result | output | W | Interleaved result word |

## Verification
The assertions check the following on every cycle, against the operands from the cycle before:
- the lowest and the highest result bit pairs for each variant;
- that the count of set bits is preserved;
- that every odd result bit is zero whenever source B is zero.

Some properties relate several operand pairs to each other, and only the bench scenarios can show them:
- that the unselected halves have no effect;
- that squaring matches a carry-less self-multiply;
- that the low and high results join into the full interleave;
- the reset value and the hold between edges.

The bench runs an exhaustive sweep of all operand pairs and both variants on an 8-bit unit.

// File: rtl/bitmix_pkg.sv
// Package: shared types for the bit interleave shuffle unit.
// Assumes nothing beyond the standard language.
package bitmix_pkg;

    // Which half of each source word feeds the interleave.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_sel_e;

endpackage

// File: rtl/bitmix_half_pick.sv
// Module: bitmix_half_pick
// Selects the lower or upper half of one W-bit source word.
// Assumes W is even.
module bitmix_half_pick
    import bitmix_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   word_in,
    input  half_sel_e      which,
    output logic [W/2-1:0] half_out
);
    localparam int H = W / 2;

    // Multiplex the chosen half onto the output.
    always_comb begin
        if (which == HALF_HIGH) begin
            half_out = word_in[W-1:H];
        end else begin
            half_out = word_in[H-1:0];
        end
    end
endmodule

// File: rtl/bitmix_weave.sv
// Module: bitmix_weave
// Wires two H-bit halves into one 2H-bit word.
// Bit 2i comes from lane A and bit 2i+1 comes from lane B.
// Pure wiring: the module adds no logic depth.
module bitmix_weave #(
    parameter int H = 16
) (
    input  logic [H-1:0]   lane_a,
    input  logic [H-1:0]   lane_b,
    output logic [2*H-1:0] woven
);
    // One pair of output bits for each input bit position.
    for (genvar i = 0; i < H; i++) begin : g_pair
        assign woven[2*i]   = lane_a[i];
        assign woven[2*i+1] = lane_b[i];
    end
endmodule

// File: rtl/bitmix_stage.sv
// Module: bitmix_stage
// Optional output register with a synchronous active-low reset.
// When REG_OUT is 0 the data passes straight through.
module bitmix_stage #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    if (REG_OUT) begin : g_reg
        logic [W-1:0] q_r;

        // Capture the result on each clock edge, and clear it during reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
            end else begin
                q_r <= d_in;
            end
        end

        assign q_out = q_r;
    end else begin : g_comb
        assign q_out = d_in;
    end
endmodule

// File: rtl/bitmix_shuffle_unit.sv
// Module: bitmix_shuffle_unit (top)
// Interleaves the selected halves of two source words bit by bit.
// Source A supplies the even result bits and source B the odd ones.
// Assumes W is even and at least 4.
module bitmix_shuffle_unit
    import bitmix_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         hi_sel,
    output logic [W-1:0] result
);
    localparam int H = W / 2;

    half_sel_e    which;
    logic [H-1:0] half_a;
    logic [H-1:0] half_b;
    logic [W-1:0] woven;

    // Turn the select pin into the typed half choice.
    always_comb begin
        which = hi_sel ? HALF_HIGH : HALF_LOW;
    end

    bitmix_half_pick #(.W(W)) u_pick_a (
        .word_in (src_a),
        .which   (which),
        .half_out(half_a)
    );

    bitmix_half_pick #(.W(W)) u_pick_b (
        .word_in (src_b),
        .which   (which),
        .half_out(half_b)
    );

    bitmix_weave #(.H(H)) u_weave (
        .lane_a(half_a),
        .lane_b(half_b),
        .woven (woven)
    );

    bitmix_stage #(.W(W), .REG_OUT(REG_OUT)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (woven),
        .q_out(result)
    );
endmodule

// File: rtl/bitmix_shuffle_chk.sv
// Module: bitmix_shuffle_chk
// Assertion checker bound to bitmix_shuffle_unit.
// Compares the result against the operands seen one cycle earlier when
// the output register is present, and in the same cycle when it is not.
module bitmix_shuffle_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic         hi_sel,
    input logic [W-1:0] result
);
    localparam int H = W / 2;

    // Mask that covers the odd bit positions of the result.
    function automatic logic [W-1:0] odd_mask();
        logic [W-1:0] m;
        m = '0;
        for (int i = 0; i < H; i++) begin
            m[2*i+1] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [W-1:0] ODD_MASK = odd_mask();

    logic         armed;
    logic [W-1:0] p_a;
    logic [W-1:0] p_b;
    logic         p_hi;

    // Arm the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    if (REG_OUT) begin : g_delayed
        // Operands of the previous cycle.
        always_ff @(posedge clk) begin
            p_a  <= src_a;
            p_b  <= src_b;
            p_hi <= hi_sel;
        end
    end else begin : g_direct
        // Operands of the current cycle.
        always_comb begin
            p_a  = src_a;
            p_b  = src_b;
            p_hi = hi_sel;
        end
    end

    // R1: the lowest bit pair of the low variant comes from bit 0 of each source.
    assert_low_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !p_hi) |-> (result[0] == p_a[0] && result[1] == p_b[0]));

    // R2: the highest bit pair of the high variant comes from the top bit of each source.
    assert_high_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && p_hi) |-> (result[W-2] == p_a[W-1] && result[W-1] == p_b[W-1]));

    // R1 and R2: the number of set bits equals that of the two selected halves.
    assert_popcount_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ($countones(result) ==
                   (p_hi ? ($countones(p_a[W-1:H]) + $countones(p_b[W-1:H]))
                         : ($countones(p_a[H-1:0]) + $countones(p_b[H-1:0])))));

    // R5: a zero source B leaves every odd result bit clear.
    assert_square_odd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && p_b == '0) |-> ((result & ODD_MASK) == '0));
endmodule

bind bitmix_shuffle_unit bitmix_shuffle_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .src_a (src_a),
    .src_b (src_b),
    .hi_sel(hi_sel),
    .result(result)
);

// File: tb/bitmix_shuffle_unit_tb.sv
// Bench: exhaustive sweep of an 8-bit unit with the output register present.
module bitmix_shuffle_unit_tb;
    localparam int W = 8;
    localparam int H = W / 2;
    localparam int N = 1 << W;
    localparam int NH = 1 << H;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         hi_sel = 1'b0;
    logic [W-1:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ref_lo [NH][NH];
    logic [W-1:0] ref_hi [NH][NH];

    always #2 clk = ~clk;

    bitmix_shuffle_unit #(.W(W), .REG_OUT(1'b1)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .src_a (src_a),
        .src_b (src_b),
        .hi_sel(hi_sel),
        .result(result)
    );

    // Loop model of the interleave of two half words.
    function automatic logic [W-1:0] weave_model(logic [H-1:0] x, logic [H-1:0] y);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < H; i++) begin
            r[2*i]   = x[i];
            r[2*i+1] = y[i];
        end
        return r;
    endfunction

    // Carry-less product of a half word with itself.
    function automatic logic [W-1:0] clmul_sq(logic [H-1:0] x);
        logic [W-1:0] acc;
        acc = '0;
        for (int i = 0; i < H; i++) begin
            if (x[i]) acc = acc ^ (W'(x) << i);
        end
        return acc;
    endfunction

    // Full 2W-bit interleave of the two words.
    function automatic logic [2*W-1:0] full_model(logic [W-1:0] x, logic [W-1:0] y);
        logic [2*W-1:0] r;
        r = '0;
        for (int j = 0; j < W; j++) begin
            r[2*j]   = x[j];
            r[2*j+1] = y[j];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operand set at a falling edge and return the result one edge later.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic hs, output logic [W-1:0] r);
        src_a  = a;
        src_b  = b;
        hi_sel = hs;
        @(posedge clk);
        @(negedge clk);
        r = result;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        logic [W-1:0] r_lo;
        logic [W-1:0] exp;

        src_a = 8'hFF;
        src_b = 8'hA5;
        repeat (3) @(negedge clk);
        // R8: the registered result is held at zero during reset.
        check(result == '0, "R8 reset value", 16'(result), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                // Low variant.
                apply(W'(a), W'(b), 1'b0, r);
                exp = weave_model(H'(a), H'(b));
                check(r == exp, "R1 low interleave", 16'(r), 16'(exp));
                if (a < NH && b < NH) ref_lo[a][b] = r;
                check(r == ref_lo[a % NH][b % NH], "R3 upper halves ignored",
                      16'(r), 16'(ref_lo[a % NH][b % NH]));
                if (b == 0) begin
                    exp = clmul_sq(H'(a));
                    check(r == exp, "R5 low square", 16'(r), 16'(exp));
                end
                r_lo = r;
                // High variant.
                apply(W'(a), W'(b), 1'b1, r);
                exp = weave_model(H'(a >> H), H'(b >> H));
                check(r == exp, "R2 high interleave", 16'(r), 16'(exp));
                if (a % NH == 0 && b % NH == 0) ref_hi[a / NH][b / NH] = r;
                check(r == ref_hi[a / NH][b / NH], "R4 lower halves ignored",
                      16'(r), 16'(ref_hi[a / NH][b / NH]));
                if (b == 0) begin
                    exp = clmul_sq(H'(a >> H));
                    check(r == exp, "R5 high square", 16'(r), 16'(exp));
                end
                check({r, r_lo} == full_model(W'(a), W'(b)), "R6 full interleave",
                      {r, r_lo}, full_model(W'(a), W'(b)));
            end
        end

        // R7: the result does not change between edges, then updates at the next edge.
        apply(8'h0F, 8'h00, 1'b0, r);
        src_a = 8'h03;
        #1;
        check(result == 8'h55, "R7 hold between edges", 16'(result), 16'h0055);
        @(posedge clk);
        @(negedge clk);
        check(result == 8'h05, "R7 update after edge", 16'(result), 16'h0005);

        // R8: a synchronous reset clears the result again.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(result == '0, "R8 reset clears", 16'(result), 16'h0);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule